// File: doc/BRIEF.md
# Serial EEPROM Write-Completion Timer

This block decides when an operation on a serial EEPROM is reported as finished. A shift engine reports the cycle in which the last bit of an operation left the chip and whether that operation was a write. The block then reports completion in one of two ways, chosen by `timed_wr_en`.

With `timed_wr_en` low, the block reports completion at once. It then owes a ready poll, so the next access request waits in a polling state until the EEPROM's ready line goes high. With `timed_wr_en` high, the block holds the busy status and withholds the completion interrupt and the SMI for a fixed wait of just over 10 ms. After that wait the next access is granted with no polling. Reads always complete at once. The policy in force is captured when an access is granted, so a change to `timed_wr_en` during an operation affects only a later one.

The controller has four states:
- `ST_IDLE`: not busy.
- `ST_POLL`: waiting for the EEPROM to report ready.
- `ST_XFER`: an operation is shifting.
- `ST_TWAIT`: the timed wait after a write is running.

It has these transitions:
- IDLE→XFER: a request is granted, with no poll owed.
- IDLE→POLL: a request arrives while a poll is owed.
- POLL→XFER: ready is seen.
- XFER→IDLE: immediate completion, for a read or an untimed write.
- XFER→TWAIT: a timed write ends its shifting.
- TWAIT→IDLE: the wait expires.

Top module: `eeprom_wrdone_timer`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `acc_go`, `done_irq` and `done_smi` are 0. The timed policy is off and no poll is owed.
- R2: In IDLE with no poll owed, a high `acc_req` sampled at a clock edge produces `acc_go` high for exactly one cycle after that edge. `busy` goes high in the same cycle and stays high until completion.
- R3: When a write ends shifting (`shift_done`=1, `shift_was_wr`=1) and the captured policy is untimed, the following cycle shows `busy`=0 with `done_irq` and `done_smi` both 1.
- R4: After an untimed write completes, the next request enters polling. `busy`=1 and `acc_go` stays 0 while `ee_ready` is sampled 0. `acc_go` pulses in the cycle after `ee_ready` is sampled 1.
- R5: When a write ends shifting under the timed policy, `busy` stays 1 and `done_irq`/`done_smi` stay 0 for WAIT_CYC cycles after the strobe edge. Then `busy` falls and both pulses appear in the same cycle.
- R6: WAIT_CYC equals CLK_KHZ*WAIT_US/1000. The defaults, 50000 kHz and 10100 µs, give a 10.1 ms wait.
- R7: After a timed write completes, the next request is granted without polling, regardless of `ee_ready`.
- R8: A read (`shift_was_wr`=0) completes in the cycle after its strobe under either policy and leaves no poll owed.
- R9: A request raised during the timed wait gets no `acc_go` until completion. It is granted one cycle after `busy` falls.
- R10: `timed_wr_en` is sampled only at the grant edge. Changing it later in the operation does not alter how that operation completes.
- R11: `done_irq` and `done_smi` are single-cycle pulses issued together.
- R12: `ee_ready` is ignored outside polling. A grant with no poll owed happens with `ee_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timed_wr_en | input | 1 | 1 selects the timed completion policy for writes |
| acc_req | input | 1 | Level request to start a new EEPROM access |
| shift_done | input | 1 | One-cycle strobe: last bit of the operation shifted |
| shift_was_wr | input | 1 | Qualifies `shift_done`: 1 means a write |
| ee_ready | input | 1 | EEPROM ready response during polling, 1 = ready |
| acc_go | output | 1 | One-cycle pulse: the new access may begin |
| busy | output | 1 | Start/busy status bit |
| done_irq | output | 1 | Completion interrupt pulse |
| done_smi | output | 1 | Completion SMI pulse |

## Verification
The hardest condition to reach is a request that arrives in the middle of a timed wait. The bench must show that no grant leaks out before the wait ends and that the grant follows exactly one cycle after `busy` falls. A directed sequence raises `acc_req` halfway through a timed write. It checks `acc_go` on every cycle of the wait and then checks for the late grant without polling. Random operations, each with a random policy, operation type, ready latency and shift length, mix untimed writes, which force polling, with timed writes and reads. `timed_wr_en` is flipped after every grant to confirm that the policy is captured at the grant edge.

// File: rtl/eewd_pkg.sv
package eewd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_POLL  = 2'd1,
        ST_XFER  = 2'd2,
        ST_TWAIT = 2'd3
    } eewd_state_e;

    // wait length in cycles from clock rate (kHz) and wait time (us)
    function automatic int unsigned wait_cycles(input int unsigned khz,
                                                input int unsigned us);
        return (khz * us) / 1000;
    endfunction

endpackage

// File: rtl/eewd_wait_timer.sv
module eewd_wait_timer #(
    parameter int unsigned WAIT_CYC = 505000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW   = (WAIT_CYC < 4) ? 2 : $clog2(WAIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear)
            cnt_q <= '0;
        else if (run && (cnt_q != LAST))
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    // R5: count never passes the last wait cycle
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R5: a running wait advances by one per cycle
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/eewd_ctrl_fsm.sv
module eewd_ctrl_fsm
    import eewd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic timed_wr_en,
    input  logic acc_req,
    input  logic shift_done,
    input  logic shift_was_wr,
    input  logic ee_ready,
    input  logic wait_expired,
    output logic wait_clear,
    output logic wait_run,
    output logic acc_go,
    output logic busy,
    output logic done_irq,
    output logic done_smi
);
    eewd_state_e state_q, state_d;
    logic        mode_q,  mode_d;   // policy captured at grant
    logic        owed_q,  owed_d;   // ready poll owed before next access
    logic        grant,   complete;
    logic        go_q, irq_q, smi_q;

    // next state
    always_comb begin
        state_d    = state_q;
        mode_d     = mode_q;
        owed_d     = owed_q;
        grant      = 1'b0;
        complete   = 1'b0;
        wait_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_req) begin
                    if (owed_q) state_d = ST_POLL;
                    else        grant   = 1'b1;
                end
            end
            ST_POLL: begin
                if (ee_ready) grant = 1'b1;
            end
            ST_XFER: begin
                if (shift_done) begin
                    if (shift_was_wr && mode_q) begin
                        state_d    = ST_TWAIT;
                        wait_clear = 1'b1;
                    end else begin
                        complete = 1'b1;
                        owed_d   = shift_was_wr;
                    end
                end
            end
            ST_TWAIT: begin
                if (wait_expired) begin
                    complete = 1'b1;
                    owed_d   = 1'b0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (grant) begin
            state_d = ST_XFER;
            mode_d  = timed_wr_en;
            owed_d  = 1'b0;
        end
        if (complete) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            owed_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            owed_q  <= owed_d;
        end
    end

    // output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            irq_q <= 1'b0;
            smi_q <= 1'b0;
        end else begin
            go_q  <= grant;
            irq_q <= complete;
            smi_q <= complete;
        end
    end

    assign wait_run = (state_q == ST_TWAIT);
    assign busy     = (state_q != ST_IDLE);
    assign acc_go   = go_q;
    assign done_irq = irq_q;
    assign done_smi = smi_q;

    // R3 / R8: immediate completion one cycle after the strobe
    a_r3_imm_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && shift_done && !(shift_was_wr && mode_q))
        |=> (done_irq && done_smi && !busy));

    // R5: status held and pulses withheld while the wait runs
    a_r5_hold_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWAIT && !wait_expired)
        |=> (busy && !done_irq && !done_smi));

    // R4: no grant while the EEPROM reports not ready
    a_r4_poll_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && !ee_ready) |=> !acc_go);

    // R9: no grant issued from an active operation or wait
    a_r9_no_early_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TWAIT || state_q == ST_XFER) |=> !acc_go);

    // R11: completion pulses last one cycle
    a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);

    // R2: grant pulse lasts one cycle and raises busy
    a_r2_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> (busy ##1 !acc_go));

endmodule

// File: rtl/eeprom_wrdone_timer.sv
module eeprom_wrdone_timer
    import eewd_pkg::*;
#(
    parameter int unsigned CLK_KHZ = 50000,
    parameter int unsigned WAIT_US = 10100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic timed_wr_en,
    input  logic acc_req,
    input  logic shift_done,
    input  logic shift_was_wr,
    input  logic ee_ready,
    output logic acc_go,
    output logic busy,
    output logic done_irq,
    output logic done_smi
);
    localparam int unsigned WAIT_RAW = wait_cycles(CLK_KHZ, WAIT_US);
    localparam int unsigned WAIT_CYC = (WAIT_RAW < 2) ? 2 : WAIT_RAW;

    logic wait_clear, wait_run, wait_expired;

    eewd_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wait_clear),
        .run     (wait_run),
        .expired (wait_expired)
    );

    eewd_ctrl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .timed_wr_en  (timed_wr_en),
        .acc_req      (acc_req),
        .shift_done   (shift_done),
        .shift_was_wr (shift_was_wr),
        .ee_ready     (ee_ready),
        .wait_expired (wait_expired),
        .wait_clear   (wait_clear),
        .wait_run     (wait_run),
        .acc_go       (acc_go),
        .busy         (busy),
        .done_irq     (done_irq),
        .done_smi     (done_smi)
    );

endmodule

// File: tb/eeprom_wrdone_timer_tb.sv
module eeprom_wrdone_timer_tb;

    localparam int unsigned TB_KHZ = 50;      // scaled so the wait fits the run
    localparam int unsigned TB_US  = 10100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic timed_wr_en = 1'b0, acc_req = 1'b0, shift_done = 1'b0;
    logic shift_was_wr = 1'b0, ee_ready = 1'b0;
    logic acc_go, busy, done_irq, done_smi;

    int checks = 0;
    int fails  = 0;
    bit exp_owed = 1'b0;
    bit exp_mode = 1'b0;
    bit last_timed = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    eeprom_wrdone_timer #(.CLK_KHZ(TB_KHZ), .WAIT_US(TB_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .timed_wr_en(timed_wr_en),
        .acc_req(acc_req), .shift_done(shift_done),
        .shift_was_wr(shift_was_wr), .ee_ready(ee_ready),
        .acc_go(acc_go), .busy(busy), .done_irq(done_irq),
        .done_smi(done_smi)
    );

    function automatic int exp_wait(input int khz, input int us);
        return (khz * us) / 1000;
    endfunction

    localparam int W = exp_wait(TB_KHZ, TB_US);

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic grant(input bit mode, input int lat);
        @(negedge clk);
        timed_wr_en = mode;
        acc_req = 1'b1;
        ee_ready = 1'b0;
        if (exp_owed) begin
            for (int i = 0; i < ((lat < 1) ? 1 : lat); i++) begin
                @(negedge clk);
                chk("R4 go held", acc_go, 1'b0);
                chk("R4 busy poll", busy, 1'b1);
            end
            ee_ready = 1'b1;
            @(negedge clk);
            chk("R4 go after ready", acc_go, 1'b1);
        end else begin
            @(negedge clk);
            if (last_timed) chk("R7 R12 go no poll", acc_go, 1'b1);
            else            chk("R2 R12 go", acc_go, 1'b1);
        end
        chk("R2 busy on grant", busy, 1'b1);
        exp_mode = mode;
        acc_req = 1'b0;
        ee_ready = 1'b0;
        @(negedge clk);
        chk("R2 go one cycle", acc_go, 1'b0);
        timed_wr_en = 1'($urandom % 2);  // R10: ignored until next grant
    endtask

    task automatic finish(input bit wr, input int len, input bit early);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            chk("R2 busy xfer", busy, 1'b1);
            chk("R11 no irq xfer", done_irq, 1'b0);
        end
        shift_done = 1'b1;
        shift_was_wr = wr;
        @(negedge clk);
        shift_done = 1'b0;
        if (wr && exp_mode) begin
            for (int k = 0; k < W; k++) begin
                if (k != 0) @(negedge clk);
                if (early && k == W / 2) acc_req = 1'b1;
                chk("R5 R10 busy wait", busy, 1'b1);
                chk("R5 irq withheld", done_irq, 1'b0);
                chk("R5 smi withheld", done_smi, 1'b0);
                if (early) chk("R9 no go in wait", acc_go, 1'b0);
            end
            @(negedge clk);
            chk("R5 R6 busy end", busy, 1'b0);
            chk("R5 R6 irq", done_irq, 1'b1);
            chk("R5 R11 smi", done_smi, 1'b1);
            exp_owed = 1'b0;
            last_timed = 1'b1;
        end else begin
            chk(wr ? "R3 R10 busy low" : "R8 busy low", busy, 1'b0);
            chk(wr ? "R3 irq" : "R8 irq", done_irq, 1'b1);
            chk(wr ? "R3 R11 smi" : "R8 R11 smi", done_smi, 1'b1);
            exp_owed = wr;
            last_timed = 1'b0;
        end
        if (early) begin
            exp_mode = timed_wr_en;
            @(negedge clk);
            chk("R9 R7 late go", acc_go, 1'b1);
            chk("R9 busy again", busy, 1'b1);
            chk("R11 irq pulse", done_irq, 1'b0);
            acc_req = 1'b0;
            @(negedge clk);
            chk("R2 go one cycle", acc_go, 1'b0);
        end else begin
            @(negedge clk);
            chk("R11 irq pulse", done_irq, 1'b0);
            chk("R11 smi pulse", done_smi, 1'b0);
            chk("R3 idle", busy, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 1'b0);
        chk("R1 irq in reset", done_irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", busy, 1'b0);
        chk("R1 go", acc_go, 1'b0);
        chk("R1 irq", done_irq, 1'b0);
        chk("R1 smi", done_smi, 1'b0);

        // directed: untimed write, then polled access
        grant(1'b0, 0);
        finish(1'b1, 2, 1'b0);
        grant(1'b0, 3);
        // R10: policy set to timed at grant, flipped afterwards
        finish(1'b0, 1, 1'b0);
        grant(1'b1, 0);
        timed_wr_en = 1'b0;
        finish(1'b1, 3, 1'b1);     // R9: request during the wait
        timed_wr_en = 1'b1;
        finish(1'b0, 2, 1'b0);     // R8: read completes immediately
        grant(1'b0, 0);
        timed_wr_en = 1'b1;
        finish(1'b1, 1, 1'b0);     // R10: stays untimed
        grant(1'b1, 2);

        finish(1'b1, 0, 1'b0);

        // random mix
        for (int n = 0; n < 30; n++) begin
            grant(1'($urandom % 2), int'($urandom % 6));
            finish(1'($urandom % 2), int'($urandom % 5), 1'b0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule